// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that escalates in steps. It watches one bit of a free-running time base. Each rising transition of that bit is one expiry, and each expiry advances a two-flag status. The first expiry arms the watchdog. The second sets an interrupt status, which reaches the interrupt output when it is enabled. The third requests a reset of a kind chosen in the control register. Software keeps the watchdog quiet by clearing the status flags with write-one-to-clear writes before the next expiry.

The watched bit comes from a two-bit period code. In table mode (parameter `EXT_MODE` = 0) the code indexes four bit positions set by parameters. In extended mode (`EXT_MODE` = 1) a four-bit extension field joins the code to form a six-bit value, and that value counts down from the top of a 64-bit time base.

The block only asserts a reset request and its kind. Acting on that request belongs to the system that surrounds it.

Top module: `wdog_escalator`

## Requirements
- R1: In table mode the period code in control bits 31:30 selects time-base bit PER0, PER1, PER2 or PER3 for codes 0 to 3. The defaults are 16, 20, 24 and 28.
- R2: In extended mode the watched bit index is 63 − (code | ext << 2), where ext is control bits 20:17.
- R3: An expiry is a 0-to-1 change of the watched bit between two consecutive clock edges. A bit that stays high causes no further expiry. The first sample after reset, and the first sample after any control write, never counts as an expiry.
- R4: An expiry with {armed, irq-status} = {status bit 31, status bit 30} equal to 00 or 01 sets status bit 31.
- R5: An expiry with {armed, irq-status} = 10 sets status bit 30.
- R6: `wd_irq` is high exactly when status bit 30 and control bit 27 (interrupt enable) are both 1.
- R7: An expiry with {armed, irq-status} = 11 and a non-zero reset-control field (control bits 29:28) does three things. It copies that field into status bits 29:28. It raises `rst_req` for exactly one cycle. It presents the same code on `rst_kind`, which holds it until the next request.
- R8: With the reset-control field at 0, an expiry in state 11 raises no request and leaves status bits 29:28 and `rst_kind` unchanged.
- R9: A status write with `sts_clr_we` clears every status bit (31, 30, 29:28) whose data bit is 1 and leaves the others alone. If an expiry sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: Control readback returns the stored fields at bits 31:30, 29:28, 27 and 20:17, with every other bit 0. Status readback has bits 27:0 at 0.
- R11: After reset, both registers read 0 and `wd_irq`, `rst_req` and `rst_kind` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tbase | input | TB_W | Time-base value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_data | input | 32 | Status clear mask, one bit per status bit |
| ctl_q | output | 32 | Control register readback |
| sts_q | output | 32 | Status register readback |
| wd_irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset kind of the latest request |

## Verification
The bench holds the watched bit high across several cycles to check that it counts as one expiry, not many. A design that tested the level instead of the edge would run straight through to a reset.

It also raises the bit in the cycle right after a control write. A design that compared the new bit against the old bit's history would fire a false expiry there.

Other cases check the escalation order and the masking rules:
- **State 01:** an expiry must re-arm the watchdog, not skip ahead to a reset.
- **Clear versus expiry:** a clear of the interrupt status that lands on the same edge as the expiry setting it must lose. A design that favoured the clear would drop an interrupt.
- **Reset control 0:** the final expiry must do nothing.
- **Interrupt enable off:** a pending status must not reach `wd_irq`.

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
  parameter int TB_W     = 64,
  parameter bit EXT_MODE = 1'b0,
  parameter int PER0     = 16,
  parameter int PER1     = 20,
  parameter int PER2     = 24,
  parameter int PER3     = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tbase,
  input  logic            ctl_we,
  input  logic [31:0]     ctl_wdata,
  input  logic            sts_clr_we,
  input  logic [31:0]     sts_clr_data,
  output logic [31:0]     ctl_q,
  output logic [31:0]     sts_q,
  output logic            wd_irq,
  output logic            rst_req,
  output logic [1:0]      rst_kind
);
  localparam int IDX_W = $clog2(TB_W);

  logic [1:0]       per_code, rst_ctl, wrs;
  logic [3:0]       per_ext;
  logic             irq_en, armed, wis, sel_q;
  logic [IDX_W-1:0] idx;
  logic             sel, expiry, fire;
  logic             clr_armed, clr_wis;
  logic [1:0]       clr_wrs;
  logic             unused_bits;

  generate
    if (EXT_MODE) begin : g_ext
      logic [5:0] code;
      assign code = {per_ext, per_code};
      assign idx  = IDX_W'(6'd63 - code);
    end else begin : g_tbl
      always_comb begin
        case (per_code)
          2'd0:    idx = IDX_W'(PER0);
          2'd1:    idx = IDX_W'(PER1);
          2'd2:    idx = IDX_W'(PER2);
          default: idx = IDX_W'(PER3);
        endcase
      end
    end
  endgenerate

  assign sel    = tbase[idx];
  assign expiry = sel & ~sel_q;
  assign fire   = expiry & armed & wis & (rst_ctl != 2'b00);

  assign clr_armed = sts_clr_we & sts_clr_data[31];
  assign clr_wis   = sts_clr_we & sts_clr_data[30];
  assign clr_wrs   = sts_clr_we ? sts_clr_data[29:28] : 2'b00;

  // a control write restarts edge tracking so a new bit choice cannot fake an expiry
  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= 1'b1;
    else if (ctl_we) sel_q <= 1'b1;
    else             sel_q <= sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_code <= '0;
      rst_ctl  <= '0;
      irq_en   <= 1'b0;
      per_ext  <= '0;
    end else if (ctl_we) begin
      per_code <= ctl_wdata[31:30];
      rst_ctl  <= ctl_wdata[29:28];
      irq_en   <= ctl_wdata[27];
      per_ext  <= ctl_wdata[20:17];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      wis      <= 1'b0;
      wrs      <= '0;
      rst_req  <= 1'b0;
      rst_kind <= '0;
    end else begin
      armed   <= (armed & ~clr_armed) | (expiry & ~armed);
      wis     <= (wis & ~clr_wis) | (expiry & armed & ~wis);
      wrs     <= fire ? rst_ctl : (wrs & ~clr_wrs);
      rst_req <= fire;
      if (fire) rst_kind <= rst_ctl;
    end
  end

  assign ctl_q  = {per_code, rst_ctl, irq_en, 6'b0, per_ext, 17'b0};
  assign sts_q  = {armed, wis, wrs, 28'b0};
  assign wd_irq = wis & irq_en;

  assign unused_bits = ^{ctl_wdata[26:21], ctl_wdata[16:0], sts_clr_data[27:0]};
endmodule

module wdog_escalator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctl_q,
  input logic [31:0] sts_q,
  input logic        wd_irq,
  input logic        rst_req,
  input logic [1:0]  rst_kind
);
  p_wis_after_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[30]) |-> $past(sts_q[31]));

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> (sts_q[30] && ctl_q[27]));

  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_req_from_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(sts_q[31]) && $past(sts_q[30])));

  p_req_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_kind != 2'b00 && sts_q[29:28] == rst_kind));

  p_no_req_rc0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(ctl_q[29:28]) != 2'b00));

  p_kind_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |-> $stable(rst_kind));

  p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[26:21] == 6'b0 && ctl_q[16:0] == 17'b0 && sts_q[27:0] == 28'b0));
endmodule

bind wdog_escalator wdog_escalator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .sts_q(sts_q),
  .wd_irq(wd_irq), .rst_req(rst_req), .rst_kind(rst_kind)
);

// File: tb/tb_wdog_escalator.sv
module tb_wdog_escalator;
  localparam int CLK_P = 10;
  localparam logic [63:0] B16 = 64'h0000_0000_0001_0000;
  localparam logic [63:0] B20 = 64'h0000_0000_0010_0000;
  localparam logic [63:0] B49 = 64'h0002_0000_0000_0000;
  localparam logic [63:0] B50 = 64'h0004_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] tbase = '0;
  logic ctl_we = 1'b0, sts_clr_we = 1'b0;
  logic [31:0] ctl_wdata = '0, sts_clr_data = '0;
  logic [31:0] ctl_q, sts_q;
  logic wd_irq, rst_req;
  logic [1:0] rst_kind;

  logic [63:0] tbx = '0;
  logic cwx = 1'b0, swx = 1'b0;
  logic [31:0] cdx = '0, sdx = '0;
  logic [31:0] ctlx_q, stsx_q;
  logic irqx, reqx;
  logic [1:0] kindx;

  int n_run = 0, n_fail = 0;

  typedef struct {
    string       tag;
    logic [67:0] exp;
  } item_t;
  item_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  wdog_escalator dut (
    .clk(clk), .rst_n(rst_n), .tbase(tbase), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data), .ctl_q(ctl_q), .sts_q(sts_q),
    .wd_irq(wd_irq), .rst_req(rst_req), .rst_kind(rst_kind));

  wdog_escalator #(.EXT_MODE(1'b1)) dut_ext (
    .clk(clk), .rst_n(rst_n), .tbase(tbx), .ctl_we(cwx), .ctl_wdata(cdx),
    .sts_clr_we(swx), .sts_clr_data(sdx), .ctl_q(ctlx_q), .sts_q(stsx_q),
    .wd_irq(irqx), .rst_req(reqx), .rst_kind(kindx));

  task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [63:0] t, input logic cw, input logic [31:0] cd,
                      input logic sw, input logic [31:0] sd, input logic [31:0] ectl,
                      input logic [3:0] est, input logic eirq, input logic ereq,
                      input logic [1:0] ekind, input string tag);
    item_t it;
    @(negedge clk);
    tbase = t; ctl_we = cw; ctl_wdata = cd; sts_clr_we = sw; sts_clr_data = sd;
    it.tag = tag;
    it.exp = {ectl, est, 28'b0, eirq, ereq, ekind};
    sb.push_back(it);
  endtask

  task automatic xstep(input logic [63:0] t, input logic cw, input logic [31:0] cd,
                       input logic [31:0] ectl, input logic [3:0] est, input string tag);
    @(negedge clk);
    tbx = t; cwx = cw; cdx = cd;
    @(posedge clk); #1;
    chk({ctlx_q, stsx_q} == {ectl, est, 28'b0}, tag, {4'b0, ctlx_q, stsx_q}, {4'b0, ectl, est, 28'b0});
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        item_t it;
        logic [67:0] act;
        it = sb.pop_front();
        act = {ctl_q, sts_q, wd_irq, rst_req, rst_kind};
        chk(act == it.exp, it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state on both instances
    chk({ctl_q, sts_q, wd_irq, rst_req, rst_kind} == '0, "R11",
        {ctl_q, sts_q, wd_irq, rst_req, rst_kind}, '0);
    chk({ctlx_q, stsx_q} == '0, "R11", {4'b0, ctlx_q, stsx_q}, '0);

    step(0,   1, 32'h2800_0000, 0, 0,            32'h2800_0000, 4'b0000, 0, 0, 2'd0, "R10");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b0000, 0, 0, 2'd0, "R3");
    step(0,   0, 0, 0, 0,                        32'h2800_0000, 4'b0000, 0, 0, 2'd0, "R3");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1000, 0, 0, 2'd0, "R4");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1000, 0, 0, 2'd0, "R3");
    step(0,   0, 0, 0, 0,                        32'h2800_0000, 4'b1000, 0, 0, 2'd0, "R4");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1100, 1, 0, 2'd0, "R5");
    step(0,   0, 0, 1, 32'h4000_0000,            32'h2800_0000, 4'b1000, 0, 0, 2'd0, "R9");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1100, 1, 0, 2'd0, "R6");
    step(0,   0, 0, 0, 0,                        32'h2800_0000, 4'b1100, 1, 0, 2'd0, "R6");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1110, 1, 1, 2'd2, "R7");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1110, 1, 0, 2'd2, "R7");
    step(0,   0, 0, 1, 32'hF000_0000,            32'h2800_0000, 4'b0000, 0, 0, 2'd2, "R9");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1000, 0, 0, 2'd2, "R4");
    step(0,   0, 0, 0, 0,                        32'h2800_0000, 4'b1000, 0, 0, 2'd2, "R4");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1100, 1, 0, 2'd2, "R5");
    step(0,   0, 0, 1, 32'h8000_0000,            32'h2800_0000, 4'b0100, 1, 0, 2'd2, "R9");
    step(B16, 0, 0, 0, 0,                        32'h2800_0000, 4'b1100, 1, 0, 2'd2, "R4");
    step(0,   0, 0, 1, 32'h4000_0000,            32'h2800_0000, 4'b1000, 0, 0, 2'd2, "R9");
    step(B16, 0, 0, 1, 32'h4000_0000,            32'h2800_0000, 4'b1100, 1, 0, 2'd2, "R9");
    step(0,   1, 32'h0000_0000, 0, 0,            32'h0000_0000, 4'b1100, 0, 0, 2'd2, "R6");
    step(B16, 0, 0, 0, 0,                        32'h0000_0000, 4'b1100, 0, 0, 2'd2, "R3");
    step(0,   0, 0, 0, 0,                        32'h0000_0000, 4'b1100, 0, 0, 2'd2, "R8");
    step(B16, 0, 0, 0, 0,                        32'h0000_0000, 4'b1100, 0, 0, 2'd2, "R8");
    step(0,   1, 32'h4800_0000, 1, 32'hF000_0000, 32'h4800_0000, 4'b0000, 0, 0, 2'd2, "R1");
    step(0,   0, 0, 0, 0,                        32'h4800_0000, 4'b0000, 0, 0, 2'd2, "R1");
    step(B16, 0, 0, 0, 0,                        32'h4800_0000, 4'b0000, 0, 0, 2'd2, "R1");
    step(B20, 0, 0, 0, 0,                        32'h4800_0000, 4'b1000, 0, 0, 2'd2, "R1");
    step(0,   1, 32'hFFFF_FFFF, 0, 0,            32'hF81E_0000, 4'b1000, 0, 0, 2'd2, "R10");
    @(negedge clk);
    ctl_we = 1'b0; sts_clr_we = 1'b0; tbase = '0;
    wait (sb.size() == 0);

    // R2 extended mode: code 1, ext 3 -> bit 63 - 13 = 50
    xstep(0,   1, 32'h4006_0000, 32'h4006_0000, 4'b0000, "R2");
    xstep(B49, 0, 0,             32'h4006_0000, 4'b0000, "R2");
    xstep(0,   0, 0,             32'h4006_0000, 4'b0000, "R2");
    xstep(B50, 0, 0,             32'h4006_0000, 4'b1000, "R2");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule